// File: doc/BRIEF.md
# I2C Controller Data and Status Flag Unit

This block holds the byte registers and the status flags of a byte-oriented I2C controller, and it raises the controller's interrupt request. On one side is a CPU register bus. That bus writes a transmit byte, reads the received byte, reads the status byte, and can mark a data read as a debugger access. On the other side is the bit-level I2C engine. The engine pulls transmit bytes through a valid/ready handshake and pushes received bytes with a single-cycle pulse. It also signals acknowledge results and its shifting phases.

On the transmit side, `tx_valid` stays high while a byte is pending and the controller is enabled. The byte leaves the register on the cycle where `tx_valid` and `tx_ready` are both high. The engine applies back-pressure by holding `tx_ready` low, and the byte then stays in place. The receive side has no back-pressure: a new `rx_valid` pulse overwrites the held byte. The shift register that moves bits on the wire lives in the engine and cannot be reached from the bus.

Top module: `twi_flag_unit`

## Requirements
- R1: After reset, the status byte is 0x80 (only the transmit-empty flag is set), `irq` is 0 and `tx_valid` is 0.
- R2: Status bit positions are as follows. Bit 7 is transmit-empty, bit 6 is receive-full, bit 5 is acknowledge, bit 4 is ten-bit address, bit 3 is read direction, bit 2 is address hit, bit 1 is data select and bit 0 is nack interrupt. Bits 4 to 0 copy the levels `eng_ten_bit`, `eng_rd_dir`, `eng_addr_hit`, `eng_data_sel` and `eng_nack_intr` one clock later.
- R3: A bus data write loads `bus_wdata` into the transmit byte, which appears on `tx_data`, and clears transmit-empty. `tx_valid` is `ctl_en` AND NOT transmit-empty. A `tx_valid`/`tx_ready` handshake sets transmit-empty on the next clock.
- R4: An `rx_valid` pulse while `ctl_en` is 1 latches `rx_data` as the received byte and sets receive-full. When `bus_stat_rd` is 0, `bus_rdata` shows the received byte.
- R5: A bus data read clears receive-full unless `bus_dbg_rd` is 1 in the same cycle.
- R6: The acknowledge flag is set by an `eng_ack` pulse and cleared by an `eng_nack` pulse.
- R7: When a set event and a clear event reach one flag in the same cycle, the flag ends up set. This applies to transmit-empty, receive-full and acknowledge.
- R8: `irq` is registered. After each clock it equals (transmit-empty AND `ctl_txi_en` AND `ctl_en` AND NOT mask) OR receive-full, evaluated on the values held before that clock.
- R9: The transmit-empty term is masked while `eng_rx_shift` is 1. It is also masked while `eng_addr_shift` is 1 and the registered read-direction bit is 1.
- R10: While `ctl_en` is 0, `tx_valid` is 0, `rx_valid` changes neither the received byte nor receive-full, and acknowledge is cleared.
- R11: `bus_stat_rd` selects the status byte onto `bus_rdata` and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_en | input | 1 | Controller enable |
| ctl_txi_en | input | 1 | Transmit-empty interrupt enable |
| bus_data_wr | input | 1 | Bus write strobe for the data register |
| bus_wdata | input | 8 | Bus write data |
| bus_data_rd | input | 1 | Bus read strobe for the data register |
| bus_dbg_rd | input | 1 | Marks the current data read as a debugger access |
| bus_stat_rd | input | 1 | Bus read strobe for the status register |
| bus_rdata | output | 8 | Read data: the status byte or the received byte |
| tx_valid | output | 1 | A transmit byte is pending |
| tx_ready | input | 1 | The engine accepts the transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Byte-received pulse |
| rx_data | input | 8 | Received byte |
| eng_ack | input | 1 | Acknowledge-sampled pulse |
| eng_nack | input | 1 | Not-acknowledge-sampled pulse |
| eng_rx_shift | input | 1 | Engine is shifting in a received byte |
| eng_addr_shift | input | 1 | Engine is shifting an address |
| eng_ten_bit | input | 1 | Ten-bit addressing level |
| eng_rd_dir | input | 1 | Read-direction level |
| eng_addr_hit | input | 1 | Address-hit level |
| eng_data_sel | input | 1 | Data-select level |
| eng_nack_intr | input | 1 | Nack-interrupt level |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs. The engine event inputs (`rx_valid`, `eng_ack`, `eng_nack`) are pulses sampled on one clock. `tx_ready` only has an effect while `tx_valid` is high. The bus strobes are cycle-qualified and change away from the active edge. The stimulus follows these assumptions: every pulse is raised for exactly one clock and dropped shortly after the edge, and the status byte is read in the middle of a cycle. The same-cycle collisions of set and clear events are driven on purpose, because the flag priority depends on them.

// File: rtl/twi_flag_pkg.sv
package twi_flag_pkg;
  localparam int STAT_W = 8;
  localparam int FLAG_N = 3;   // flags with set/clear events
  localparam int MIRR_N = 5;   // status bits copied from engine levels

  // flag cell indices
  localparam int F_TXE = 0;
  localparam int F_RXF = 1;
  localparam int F_ACK = 2;

  // bit order is read by software, so it is fixed
  typedef struct packed {
    logic txe;
    logic rxf;
    logic ack;
    logic ten;
    logic rdd;
    logic hit;
    logic dsel;
    logic nint;
  } stat_t;
endpackage

// File: rtl/twi_flag_cell.sv
module twi_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= RST_VAL;
    else if (set_i) flag_o <= 1'b1;   // set has priority
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/twi_byte_regs.sv
module twi_byte_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_in,
  input  logic              rx_load,
  input  logic [DATA_W-1:0] rx_in,
  output logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rx_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte <= '0;
      rx_byte <= '0;
    end else begin
      if (tx_load) tx_byte <= tx_in;
      if (rx_load) rx_byte <= rx_in;
    end
  end
endmodule

// File: rtl/twi_irq_gen.sv
module twi_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic txi_en,
  input  logic txe,
  input  logic rxf,
  input  logic rdd,
  input  logic rx_shift,
  input  logic addr_shift,
  output logic irq
);
  logic tx_mask;
  logic irq_d;

  always_comb begin
    tx_mask = rx_shift | (addr_shift & rdd);
    irq_d   = (txe & txi_en & en & ~tx_mask) | rxf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/twi_flag_unit.sv
module twi_flag_unit
  import twi_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_en,
  input  logic              ctl_txi_en,
  input  logic              bus_data_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_data_rd,
  input  logic              bus_dbg_rd,
  input  logic              bus_stat_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              eng_ack,
  input  logic              eng_nack,
  input  logic              eng_rx_shift,
  input  logic              eng_addr_shift,
  input  logic              eng_ten_bit,
  input  logic              eng_rd_dir,
  input  logic              eng_addr_hit,
  input  logic              eng_data_sel,
  input  logic              eng_nack_intr,
  output logic              irq
);
  localparam logic [FLAG_N-1:0] FLAG_RST = 3'b001; // only transmit-empty set

  logic [FLAG_N-1:0] f_set, f_clr, f_q;
  logic [MIRR_N-1:0] mirr_d, mirr_q;
  logic              rx_take;
  stat_t             stat_q;

  assign rx_take = ctl_en & rx_valid;
  assign tx_valid = ctl_en & ~f_q[F_TXE];

  always_comb begin
    f_set        = '0;
    f_clr        = '0;
    f_set[F_TXE] = tx_valid & tx_ready;
    f_clr[F_TXE] = bus_data_wr;
    f_set[F_RXF] = rx_take;
    f_clr[F_RXF] = bus_data_rd & ~bus_dbg_rd;
    f_set[F_ACK] = ctl_en & eng_ack;
    f_clr[F_ACK] = eng_nack | ~ctl_en;
  end

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    twi_flag_cell #(.RST_VAL(FLAG_RST[g])) i_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (f_set[g]),
      .clr_i  (f_clr[g]),
      .flag_o (f_q[g])
    );
  end

  assign mirr_d = {eng_ten_bit, eng_rd_dir, eng_addr_hit, eng_data_sel, eng_nack_intr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mirr_q <= '0;
    else        mirr_q <= mirr_d;
  end

  assign stat_q = {f_q[F_TXE], f_q[F_RXF], f_q[F_ACK], mirr_q};

  logic [DATA_W-1:0] rx_byte;

  twi_byte_regs #(.DATA_W(DATA_W)) i_bytes (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_load (bus_data_wr),
    .tx_in   (bus_wdata),
    .rx_load (rx_take),
    .rx_in   (rx_data),
    .tx_byte (tx_data),
    .rx_byte (rx_byte)
  );

  assign bus_rdata = bus_stat_rd ? DATA_W'(stat_q) : rx_byte;

  twi_irq_gen i_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (ctl_en),
    .txi_en     (ctl_txi_en),
    .txe        (stat_q.txe),
    .rxf        (stat_q.rxf),
    .rdd        (stat_q.rdd),
    .rx_shift   (eng_rx_shift),
    .addr_shift (eng_addr_shift),
    .irq        (irq)
  );
endmodule

// File: rtl/twi_flag_unit_chk.sv
module twi_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_en,
  input logic       bus_data_wr,
  input logic       bus_data_rd,
  input logic       bus_dbg_rd,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       eng_ack,
  input logic       eng_nack,
  input logic       eng_rx_shift,
  input logic       irq,
  input logic [7:0] stat_q
);
  AST_TX_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> stat_q[7]); // R7
  AST_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_data_wr && !(tx_valid && tx_ready)) |=> !stat_q[7]); // R3
  AST_EMPTY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[7]) |-> $past(tx_valid && tx_ready)); // R3
  AST_RX_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && rx_valid) |=> stat_q[6]); // R4
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_data_rd && !bus_dbg_rd && !(ctl_en && rx_valid)) |=> !stat_q[6]); // R5
  AST_DBG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_data_rd && bus_dbg_rd && stat_q[6]) |=> stat_q[6]); // R5
  AST_ACK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && eng_ack) |=> stat_q[5]); // R6
  AST_NACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_nack && !eng_ack) |=> !stat_q[5]); // R6
  AST_OFF_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> !stat_q[5]); // R10
  AST_FULL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[6] |=> irq); // R8
  AST_RXSHIFT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_shift && !stat_q[6]) |=> !irq); // R9
endmodule

bind twi_flag_unit twi_flag_unit_chk i_chk (.*);

// File: tb/test_twi_flag_unit.sv
`timescale 1ns/1ps
module test_twi_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_en = 1'b0, ctl_txi_en = 1'b0;
  logic       bus_data_wr = 1'b0, bus_data_rd = 1'b0, bus_dbg_rd = 1'b0, bus_stat_rd = 1'b0;
  logic [7:0] bus_wdata = '0, rx_data = '0;
  logic [7:0] bus_rdata, tx_data;
  logic       tx_valid, tx_ready = 1'b0, rx_valid = 1'b0;
  logic       eng_ack = 1'b0, eng_nack = 1'b0, eng_rx_shift = 1'b0, eng_addr_shift = 1'b0;
  logic       eng_ten_bit = 1'b0, eng_rd_dir = 1'b0, eng_addr_hit = 1'b0;
  logic       eng_data_sel = 1'b0, eng_nack_intr = 1'b0;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  twi_flag_unit i_twi_flag_unit (.*);

  typedef struct packed {
    logic wr, rd, dbg, rxv, txr, ack, nack, rxs, ads, rdd, txi;
    logic [7:0] st;
    logic irq;
  } vec_t;

  // wr rd dbg rxv txr ack nack rxs ads rdd txi | status irq
  localparam vec_t VECS [0:18] = '{
    '{0,0,0,0,0,0,0,0,0,0,1, 8'h80, 1},  // R8 empty raises irq
    '{1,0,0,0,0,0,0,0,0,0,1, 8'h00, 1},  // R3 write clears empty
    '{0,0,0,0,0,0,0,0,0,0,1, 8'h00, 0},  // R8
    '{0,0,0,0,1,0,0,0,0,0,1, 8'h80, 0},  // R3 handshake empties
    '{0,0,0,0,0,0,0,1,0,0,1, 8'h80, 0},  // R9 rx shift mask
    '{0,0,0,0,0,0,0,0,0,1,1, 8'h88, 1},  // R2 read-dir copy
    '{0,0,0,0,0,0,0,0,1,1,1, 8'h88, 0},  // R9 addr shift with read dir
    '{0,0,0,0,0,0,0,0,1,0,1, 8'h80, 0},  // R9 registered dir still 1
    '{0,0,0,0,0,0,0,0,1,0,1, 8'h80, 1},  // R9 write-dir addr not masked
    '{0,0,0,1,0,0,0,0,0,0,0, 8'hC0, 0},  // R4 rx full
    '{0,1,1,0,0,0,0,0,0,0,0, 8'hC0, 1},  // R5 debug read keeps
    '{0,1,0,0,0,0,0,0,0,0,0, 8'h80, 1},  // R5 read clears
    '{0,0,0,0,0,0,0,0,0,0,0, 8'h80, 0},  // R8
    '{0,1,0,1,0,0,0,0,0,0,0, 8'hC0, 0},  // R7 rx set beats read
    '{0,0,0,0,0,1,0,0,0,0,0, 8'hE0, 1},  // R6 ack set
    '{0,1,0,0,0,0,1,0,0,0,0, 8'h80, 1},  // R6 nack clears
    '{0,0,0,0,0,1,1,0,0,0,0, 8'hA0, 0},  // R7 ack beats nack
    '{1,0,0,0,0,0,0,0,0,0,0, 8'h20, 0},  // R3
    '{1,0,0,0,1,0,0,0,0,0,0, 8'hA0, 0}   // R7 handshake beats write
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_pulses();
    bus_data_wr = 0; bus_data_rd = 0; bus_dbg_rd = 0;
    rx_valid = 0; tx_ready = 0; eng_ack = 0; eng_nack = 0;
  endtask

  // one clock, then read status mid-cycle
  task automatic tick(output logic [7:0] st);
    @(posedge clk);
    #2;
    idle_pulses();
    bus_stat_rd = 1;
    #1;
    st = bus_rdata;
    bus_stat_rd = 0;
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    repeat (3) @(posedge clk);
    #3;
    bus_stat_rd = 1; #1;
    chk("R1 reset status", bus_rdata, 8'h80);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset tx_valid", tx_valid, 0);
    bus_stat_rd = 0;
    rst_n = 1;
    ctl_en = 1;
    @(negedge clk);

    for (int i = 0; i < 19; i++) begin
      bus_data_wr = VECS[i].wr; bus_data_rd = VECS[i].rd; bus_dbg_rd = VECS[i].dbg;
      rx_valid = VECS[i].rxv; tx_ready = VECS[i].txr; eng_ack = VECS[i].ack;
      eng_nack = VECS[i].nack; eng_rx_shift = VECS[i].rxs; eng_addr_shift = VECS[i].ads;
      eng_rd_dir = VECS[i].rdd; ctl_txi_en = VECS[i].txi;
      tick(st);
      chk($sformatf("R7/R8/R9 vec%0d status", i), st, VECS[i].st);
      chk($sformatf("R8/R9 vec%0d irq", i), irq, VECS[i].irq);
    end
    eng_rx_shift = 0; eng_addr_shift = 0; eng_rd_dir = 0; ctl_txi_en = 0;

    // R2 engine level copies: state is empty=1 full=0 ack=1
    eng_ten_bit = 1; eng_addr_hit = 1; eng_nack_intr = 1;
    tick(st);
    chk("R2 level copy", st, 8'hB5);
    eng_ten_bit = 0; eng_addr_hit = 0; eng_nack_intr = 0; eng_data_sel = 1;
    tick(st);
    chk("R2 data select copy", st, 8'hA2);
    eng_data_sel = 0;
    tick(st);

    // R3 transmit byte path
    bus_data_wr = 1; bus_wdata = 8'h5A;
    tick(st);
    chk("R3 tx_valid", tx_valid, 1);
    chk("R3 tx_data", tx_data, 8'h5A);
    tx_ready = 1;
    tick(st);
    chk("R3 tx_valid after take", tx_valid, 0);

    // R4 receive byte path
    rx_valid = 1; rx_data = 8'h3C;
    tick(st);
    chk("R4 rx byte", bus_rdata, 8'h3C);
    chk("R4 full flag", st[6], 1);

    // R11 status read changes nothing
    bus_stat_rd = 1;
    @(posedge clk); #2; bus_stat_rd = 0;
    tick(st);
    chk("R11 status read no side effect", st, 8'hE0);

    // R10 disabled controller
    ctl_en = 0;
    rx_valid = 1; rx_data = 8'hC3;
    tick(st);
    chk("R10 ack cleared", st[5], 0);
    chk("R10 rx byte kept", bus_rdata, 8'h3C);
    bus_data_wr = 1; bus_wdata = 8'h11;
    tick(st);
    chk("R10 tx_valid off", tx_valid, 0);
    chk("R10 empty cleared by write", st[7], 0);
    ctl_en = 1; #1;
    chk("R3 tx_valid on re-enable", tx_valid, 1);
    bus_data_rd = 1;
    tick(st);
    chk("R5 read clears full", st[6], 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule